// File: doc/BRIEF.md
# Multi-Master System Bus Arbiter

Each bus master on a shared multi-master system bus has one of these arbiters beside it. The arbiter takes cycle requests from its local processor and wins the shared bus when its priority input is granted and no other master holds the bus. It then pulls the shared BUSY line low and enables its address and data drivers. A master that wants the bus but does not have it signals this on a common-request line. The master that holds the bus sees that request and decides whether to give the bus up.

Once the arbiter owns the bus, it does not give it back when its own transfer finishes. It keeps the bus idle-held, and a later local request runs on the bus at once, with no new arbitration. The bus is released only in these cases:
- a higher-priority master takes the priority input away;
- the any-request override is set and a lower-priority master is waiting;
- resident-bus mode is selected and a master is waiting;
- halt is asserted.

Two lock inputs can suppress these releases. Lock suppresses all of them. Common-request lock suppresses only the releases caused by the common-request line. In daisy-chain use, a registered priority output passes the grant on to the next arbiter when this one is not requesting. All shared lines are active low. For BUSY and the common-request line, the block gives out open-drain enables, where 1 means pull the line low.

Top module: `mm_bus_arbiter`

## Requirements
- R1: While init_n is low, the arbiter is reset and neither holds nor requests the bus: aen_n=1, breq_n=1, busy_drv=0, creq_drv=0 and prio_out_n=1.
- R2: A requesting arbiter takes the bus at the first clock edge where prio_in_n=0 and busy_in_n=1. After that edge, aen_n=0 and busy_drv=1. While either condition is missing, it keeps waiting with aen_n=1.
- R3: A cycle request moves an idle arbiter to waiting at the next edge, with breq_n=0 and creq_drv=1. Once the arbiter owns the bus, creq_drv=0 and breq_n stays 0.
- R4: When a transfer ends (xfer_done=1) and no release condition holds, the arbiter keeps the bus (aen_n=0). A later cycle_req starts a transfer at once, even while busy_in_n=0.
- R5: If prio_in_n=1 during a transfer, the bus is kept until xfer_done. It is then released at that edge. If prio_in_n=1 while the bus is idle-held, the bus is released at the next edge.
- R6: With any_req=1 and creq_in_n=0, the bus is released at the end of every transfer.
- R7: With creq_in_n=0, any_req=0 and strap_res=0, the bus is kept after a transfer.
- R8: While lock_n=0, the bus is never released, even with prio_in_n=1, halt=1 or any_req=1. The release takes effect at the first edge after lock_n returns high, if a release condition still holds then.
- R9: While creq_lock_n=0, release requests signalled through creq_in_n are ignored. Preemption through prio_in_n still releases the bus.
- R10: With strap_res=1, a cycle_req is ignored while sys_sel=0. Also with strap_res=1, an idle-held bus is released when sys_sel=0 and creq_in_n=0. With strap_res=0, sys_sel has no effect.
- R11: halt=1 cancels a pending request at the next edge (breq_n=1). It also releases an idle-held bus, or the bus at the end of a transfer.
- R12: prio_out_n is registered. It goes to 0 one edge after prio_in_n=0 is seen while the arbiter is not requesting. Otherwise it goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| init_n | input | 1 | Asynchronous initialise, active low |
| cycle_req | input | 1 | Local processor requests a system-bus cycle |
| xfer_done | input | 1 | Current transfer cycle finishes at this edge |
| halt | input | 1 | Local processor halted |
| lock_n | input | 1 | Lock: forbid any release, active low |
| creq_lock_n | input | 1 | Ignore common-request releases, active low |
| any_req | input | 1 | Yield to any waiting master, active high |
| strap_res | input | 1 | Mode strap: 1 enables resident/system select |
| sys_sel | input | 1 | 1 selects the system bus in strapped mode |
| prio_in_n | input | 1 | Priority grant in, active low |
| busy_in_n | input | 1 | Sensed shared BUSY line, active low |
| creq_in_n | input | 1 | Sensed shared common-request line, active low |
| breq_n | output | 1 | Bus request, active low |
| prio_out_n | output | 1 | Priority out to next arbiter, active low |
| busy_drv | output | 1 | Open-drain enable pulling BUSY low |
| creq_drv | output | 1 | Open-drain enable pulling common request low |
| aen_n | output | 1 | Address/driver enable, active low |

## Verification
The assertions assume that every input is synchronous to clk and is stable at the rising edge. They also assume that the sensed shared lines show this arbiter's own drives: busy_in_n is low while busy_drv is 1, and creq_in_n is low while creq_drv is 1. The stimulus meets these assumptions as follows. It changes inputs only on the falling edge. In the random phase it derives busy_in_n and creq_in_n from the outputs just observed, with random activity from other masters added only when this arbiter is not driving the line. Pulses of xfer_done arrive in any state. The design must ignore them outside a transfer, and the reference model checks that it does.

// File: rtl/mm_bus_arbiter.sv
module mm_bus_arbiter (
  input  logic clk,
  input  logic init_n,
  input  logic cycle_req,
  input  logic xfer_done,
  input  logic halt,
  input  logic lock_n,
  input  logic creq_lock_n,
  input  logic any_req,
  input  logic strap_res,
  input  logic sys_sel,
  input  logic prio_in_n,
  input  logic busy_in_n,
  input  logic creq_in_n,
  output logic breq_n,
  output logic prio_out_n,
  output logic busy_drv,
  output logic creq_drv,
  output logic aen_n
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER, S_HELD} st_t;

  st_t st, st_nx;

  wire sys_ok    = !strap_res || sys_sel;
  wire want      = cycle_req && sys_ok && !halt;
  wire creq_seen = !creq_in_n && creq_lock_n;
  wire give_up   = lock_n && (halt || prio_in_n ||
                   (creq_seen && (any_req || (strap_res && !sys_sel))));
  wire own       = (st == S_XFER) || (st == S_HELD);
  wire req       = (st != S_IDLE);
  wire leave_to  = want;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (want) st_nx = S_WAIT;
      S_WAIT: begin
        if (halt)                          st_nx = S_IDLE;
        else if (!prio_in_n && busy_in_n)  st_nx = S_XFER;
      end
      S_XFER: if (xfer_done) begin
        if (give_up) st_nx = leave_to ? S_WAIT : S_IDLE;
        else         st_nx = S_HELD;
      end
      S_HELD: begin
        if (give_up)   st_nx = leave_to ? S_WAIT : S_IDLE;
        else if (want) st_nx = S_XFER;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) begin
      st         <= S_IDLE;
      prio_out_n <= 1'b1;
    end else begin
      st         <= st_nx;
      prio_out_n <= prio_in_n || req;
    end
  end

  assign breq_n   = !req;
  assign busy_drv = own;
  assign creq_drv = (st == S_WAIT);
  assign aen_n    = !own;

  p_grant_gate_r2: assert property (@(posedge clk) disable iff (!init_n)
    $fell(aen_n) |-> $past(!prio_in_n && busy_in_n));

  p_holder_quiet_r3: assert property (@(posedge clk) disable iff (!init_n)
    !aen_n |-> !creq_drv);

  p_release_boundary_r5: assert property (@(posedge clk) disable iff (!init_n)
    $rose(aen_n) |-> $past(xfer_done || st == S_HELD));

  p_lock_keeps_r8: assert property (@(posedge clk) disable iff (!init_n)
    ($past(!lock_n) && $past(!aen_n)) |-> !aen_n);

  p_halt_cancel_r11: assert property (@(posedge clk) disable iff (!init_n)
    (st == S_WAIT && halt) |=> breq_n);

  p_daisy_r12: assert property (@(posedge clk) disable iff (!init_n)
    !prio_out_n |-> $past(!prio_in_n && breq_n));

endmodule

// File: tb/test_mm_bus_arbiter.sv
module test_mm_bus_arbiter;
  logic clk = 0;
  logic init_n = 0;
  logic cycle_req = 0, xfer_done = 0, halt = 0;
  logic lock_n = 1, creq_lock_n = 1, any_req = 0, strap_res = 0, sys_sel = 0;
  logic prio_in_n = 1, busy_in_n = 1, creq_in_n = 1;
  logic breq_n, prio_out_n, busy_drv, creq_drv, aen_n;
  int checks = 0, errors = 0;
  int m;
  logic m_po;

  always #10 clk = ~clk;

  mm_bus_arbiter i_mm_bus_arbiter (
    .clk(clk), .init_n(init_n), .cycle_req(cycle_req), .xfer_done(xfer_done),
    .halt(halt), .lock_n(lock_n), .creq_lock_n(creq_lock_n), .any_req(any_req),
    .strap_res(strap_res), .sys_sel(sys_sel), .prio_in_n(prio_in_n),
    .busy_in_n(busy_in_n), .creq_in_n(creq_in_n), .breq_n(breq_n),
    .prio_out_n(prio_out_n), .busy_drv(busy_drv), .creq_drv(creq_drv), .aen_n(aen_n));

  // reference model: 0 idle, 1 waiting, 2 transferring, 3 holding idle
  function automatic int model_next();
    bit wanted, yield;
    wanted = cycle_req && (!strap_res || sys_sel) && !halt;
    yield = 0;
    if (lock_n) begin
      if (halt || prio_in_n) yield = 1;
      if (!creq_in_n && creq_lock_n && any_req) yield = 1;
      if (!creq_in_n && creq_lock_n && strap_res && !sys_sel) yield = 1;
    end
    case (m)
      0: return wanted ? 1 : 0;
      1: if (halt) return 0; else if (!prio_in_n && busy_in_n) return 2; else return 1;
      2: if (!xfer_done) return 2; else if (yield) return wanted ? 1 : 0; else return 3;
      default: if (yield) return wanted ? 1 : 0; else if (wanted) return 2; else return 3;
    endcase
  endfunction

  always @(posedge clk or negedge init_n)
    if (!init_n) begin m <= 0; m_po <= 1'b1; end
    else begin m <= model_next(); m_po <= prio_in_n || (m != 0); end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R2 aen_n model", aen_n, !(m >= 2));
    chk("R3 breq_n model", breq_n, (m == 0));
    chk("R2 busy_drv model", busy_drv, (m >= 2));
    chk("R3 creq_drv model", creq_drv, (m == 1));
    chk("R12 prio_out_n model", prio_out_n, m_po);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic acquire();
    cycle_req = 1; prio_in_n = 0; busy_in_n = 1;
    tick();
    cycle_req = 0;
    tick();
    busy_in_n = 0;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    chk("R1 aen_n", aen_n, 1); chk("R1 breq_n", breq_n, 1);
    chk("R1 busy_drv", busy_drv, 0); chk("R1 creq_drv", creq_drv, 0);
    chk("R1 prio_out_n", prio_out_n, 1);
    init_n = 1;

    // R2, R3: request, wait on busy, then acquire
    cycle_req = 1; prio_in_n = 0; busy_in_n = 0;
    tick();
    chk("R3 breq_n waiting", breq_n, 0); chk("R3 creq_drv waiting", creq_drv, 1);
    cycle_req = 0;
    tick();
    chk("R2 still waiting on busy", aen_n, 1);
    busy_in_n = 1;
    tick();
    chk("R2 aen_n acquired", aen_n, 0); chk("R2 busy_drv", busy_drv, 1);
    chk("R3 holder no creq", creq_drv, 0);
    busy_in_n = 0;

    // R7, R4, R5
    creq_in_n = 0; xfer_done = 1;
    tick();
    chk("R7 kept with plain creq", aen_n, 0);
    xfer_done = 0; cycle_req = 1;
    tick();
    cycle_req = 0; prio_in_n = 1;
    tick();
    chk("R4 re-entered transfer, R5 waits for end", aen_n, 0);
    xfer_done = 1;
    tick();
    chk("R5 released at transfer end", aen_n, 1);
    xfer_done = 0; prio_in_n = 0; creq_in_n = 1;

    // R6
    acquire();
    any_req = 1; creq_in_n = 0; xfer_done = 1;
    tick();
    chk("R6 any_req release", aen_n, 1); chk("R6 breq_n dropped", breq_n, 1);
    any_req = 0; creq_in_n = 1; xfer_done = 0;

    // R8
    acquire();
    lock_n = 0; prio_in_n = 1; halt = 1; any_req = 1; xfer_done = 1;
    tick();
    chk("R8 locked at transfer end", aen_n, 0);
    xfer_done = 0;
    tick();
    chk("R8 locked while held", aen_n, 0);
    lock_n = 1;
    tick();
    chk("R8 release after unlock", aen_n, 1);
    halt = 0; prio_in_n = 0; any_req = 0;

    // R9
    acquire();
    any_req = 1; creq_in_n = 0; creq_lock_n = 0; xfer_done = 1;
    tick();
    chk("R9 creq ignored", aen_n, 0);
    xfer_done = 0; prio_in_n = 1;
    tick();
    chk("R9 preemption still works", aen_n, 1);
    any_req = 0; creq_in_n = 1; creq_lock_n = 1; prio_in_n = 0;

    // R10
    strap_res = 1; sys_sel = 0; cycle_req = 1;
    tick();
    chk("R10 resident cycle ignored", breq_n, 1);
    cycle_req = 0; sys_sel = 1;
    acquire();
    creq_in_n = 0; xfer_done = 1;
    tick();
    chk("R10 kept with system select", aen_n, 0);
    xfer_done = 0; sys_sel = 0;
    tick();
    chk("R10 resident select releases", aen_n, 1);
    creq_in_n = 1; strap_res = 0; sys_sel = 0; cycle_req = 1;
    tick();
    chk("R10 select ignored unstrapped", breq_n, 0);
    cycle_req = 0;

    // R11
    busy_in_n = 0; halt = 1;
    tick();
    chk("R11 halt cancels request", breq_n, 1);
    halt = 0;
    acquire();
    xfer_done = 1;
    tick();
    xfer_done = 0; halt = 1;
    tick();
    chk("R11 halt releases held bus", aen_n, 1);
    halt = 0;

    // R12
    prio_in_n = 0;
    tick();
    chk("R12 priority passed on", prio_out_n, 0);
    cycle_req = 1; busy_in_n = 0;
    tick();
    cycle_req = 0;
    tick();
    chk("R12 priority kept while requesting", prio_out_n, 1);
    halt = 1;
    tick();
    halt = 0;

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      cycle_req   = ($urandom % 4) == 0;
      xfer_done   = ($urandom % 3) == 0;
      halt        = ($urandom % 20) == 0;
      lock_n      = ($urandom % 8) != 0;
      creq_lock_n = ($urandom % 5) != 0;
      any_req     = ($urandom % 3) == 0;
      strap_res   = ($urandom % 2) == 0;
      sys_sel     = ($urandom % 3) != 0;
      prio_in_n   = ($urandom % 4) == 0;
      busy_in_n   = busy_drv ? 1'b0 : 1'($urandom % 2);
      creq_in_n   = creq_drv ? 1'b0 : 1'($urandom % 2);
      tick();
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule